// File: doc/BRIEF.md
# Whole-Method Instruction Cache

This block is an instruction store that always contains one complete method and nothing else. The core reports each call and each return by giving the target method's start address and its length in words. The block compares that start address against the method it already holds. When they match, nothing happens. When they differ, the block raises a stall and copies the whole method, one word at a time, from a simple external read port into its local RAM. The first word goes to offset zero.

Between calls and returns, the fetch stage reads instructions with offsets relative to the method start. The cache has no per-fetch tag check and no address translation, so every fetch inside a method hits. A requested length of zero, or a length larger than the capacity, is refused with an error flag. In that case the method already cached stays loaded.

Top module: `method_cache`

## Requirements
- R1: After reset, busy, err and mem_rd are low and no method counts as loaded, so the first request misses even when its start address is 0.
- R2: A request whose start address equals that of the loaded method, with a legal length, is a hit. busy stays low, no memory read is issued, and the stored words are unchanged. The length is not compared.
- R3: A request with a legal length and a different start address is a miss. busy is high from the cycle after the request for exactly len+1 cycles.
- R4: During a miss, mem_rd is high for exactly len consecutive cycles, starting in the first busy cycle. mem_addr runs start, start+1, and so on. The memory returns the data in the cycle after mem_rd.
- R5: The word read from address start+k is stored at offset k, for every k from 0 to len-1. A length equal to the capacity is legal.
- R6: fetch_data shows the stored word at fetch_ofs one clock after fetch_ofs is presented.
- R7: A request with length 0 or length above DEPTH sets err in the next cycle, starts no fill and issues no read. The loaded method stays valid. err clears on the next accepted request that has a legal length.
- R8: A request presented while busy is high is ignored. The fill in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Call/return strobe, one cycle |
| req_start | input | ADDR_W | Start address of the target method |
| req_len | input | ADDR_W | Method length in words |
| busy | output | 1 | Stall while a method is being loaded |
| err | output | 1 | Last accepted request had an illegal length |
| mem_rd | output | 1 | External memory read strobe |
| mem_addr | output | ADDR_W | External memory word address |
| mem_rdata | input | DATA_W | Read data, valid the cycle after mem_rd |
| fetch_ofs | input | $clog2(DEPTH) | Method-relative fetch offset |
| fetch_data | output | DATA_W | Instruction word, one cycle after the offset |

## Verification
The assertions assume two things about the inputs. First, the core holds req_valid for a single cycle per call or return. Second, the memory answers every mem_rd with data exactly one cycle later. The bench meets both: its request task pulses req_valid for one cycle, and its memory model registers a value derived from the address on each mem_rd. The bench also injects one request during a fill, deliberately, to exercise the stall rule. Apart from that, it issues requests only while busy is low.

// File: rtl/method_cache.sv
module method_cache #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [ADDR_W-1:0]        req_start,
  input  logic [ADDR_W-1:0]        req_len,
  output logic                     busy,
  output logic                     err,
  output logic                     mem_rd,
  output logic [ADDR_W-1:0]        mem_addr,
  input  logic [DATA_W-1:0]        mem_rdata,
  input  logic [$clog2(DEPTH)-1:0] fetch_ofs,
  output logic [DATA_W-1:0]        fetch_data
);
  localparam int OFS_W = $clog2(DEPTH);
  localparam int CNT_W = OFS_W + 1;

  logic [DATA_W-1:0] ram [DEPTH];
  logic [ADDR_W-1:0] start_r;
  logic [CNT_W-1:0]  len_r, rd_cnt, wr_cnt;
  logic              loaded, busy_r, err_r, pend;

  wire accept  = req_valid && !busy_r;
  wire bad_len = (req_len == '0) || (req_len > ADDR_W'(DEPTH));
  wire same    = loaded && (req_start == start_r);
  wire miss    = accept && !bad_len && !same;

  assign busy     = busy_r;
  assign err      = err_r;
  assign mem_rd   = busy_r && (rd_cnt < len_r);
  assign mem_addr = start_r + ADDR_W'(rd_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_r <= '0;
      len_r   <= '0;
      rd_cnt  <= '0;
      wr_cnt  <= '0;
      loaded  <= 1'b0;
      busy_r  <= 1'b0;
      err_r   <= 1'b0;
      pend    <= 1'b0;
    end else begin
      pend <= mem_rd;
      if (accept) err_r <= bad_len;
      if (miss) begin
        busy_r  <= 1'b1;
        loaded  <= 1'b0;
        start_r <= req_start;
        len_r   <= CNT_W'(req_len);
        rd_cnt  <= '0;
        wr_cnt  <= '0;
      end else if (busy_r) begin
        if (mem_rd) rd_cnt <= rd_cnt + 1'b1;
        if (pend) begin
          wr_cnt <= wr_cnt + 1'b1;
          if (wr_cnt == len_r - 1'b1) begin
            busy_r <= 1'b0;
            loaded <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pend) ram[wr_cnt[OFS_W-1:0]] <= mem_rdata;
    fetch_data <= ram[fetch_ofs];
  end

  AST_HIT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !bad_len && same |=> !busy && !mem_rd); // R2
  AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> busy && mem_rd && mem_addr == $past(req_start)); // R3
  AST_BAD_LEN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && bad_len |=> err && !busy && !mem_rd); // R7
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && $past(mem_rd) |-> mem_addr == $past(mem_addr) + ADDR_W'(1)); // R4
  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    busy && req_valid |=> $stable(start_r)); // R8
endmodule

// File: tb/method_cache_bench.sv
module method_cache_bench;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 256;
  localparam int OFS_W  = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [ADDR_W-1:0] req_start = '0, req_len = '0;
  logic busy, err, mem_rd;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_rdata = '0, fetch_data;
  logic [OFS_W-1:0] fetch_ofs = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  method_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_method_cache (
    .clk, .rst_n, .req_valid, .req_start, .req_len, .busy, .err,
    .mem_rd, .mem_addr, .mem_rdata, .fetch_ofs, .fetch_data);

  function automatic logic [DATA_W-1:0] word_of(logic [ADDR_W-1:0] a);
    return {a ^ 16'h5a5a, a};
  endfunction

  always_ff @(posedge clk) if (mem_rd) mem_rdata <= word_of(mem_addr);

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Issues one request; counts busy cycles and verifies the read stream.
  task automatic request(logic [ADDR_W-1:0] s, logic [ADDR_W-1:0] l,
                         int exp_busy, string req, output int reads);
    int k = 0;
    bit addr_ok = 1'b1;
    reads = 0;
    @(negedge clk);
    req_valid = 1'b1; req_start = s; req_len = l;
    @(negedge clk);
    req_valid = 1'b0;
    while (busy && k < 2000) begin
      if (mem_rd) begin
        if (mem_addr != s + ADDR_W'(reads)) addr_ok = 1'b0;
        if (reads != k) addr_ok = 1'b0;
        reads++;
      end
      k++;
      @(negedge clk);
    end
    chk(k == exp_busy, req, "busy cycles", k, exp_busy);
    chk(addr_ok, req, "read address sequence", addr_ok, 1);
  endtask

  task automatic fetch_chk(int ofs, logic [DATA_W-1:0] exp, string req);
    @(negedge clk);
    fetch_ofs = OFS_W'(ofs);
    @(negedge clk);
    chk(fetch_data == exp, req, $sformatf("fetch ofs %0d", ofs), fetch_data, exp);
  endtask

  task automatic t_reset_first_miss();
    int r;
    chk(!busy && !err && !mem_rd, "R1", "idle after reset", {busy, err, mem_rd}, 0);
    request(16'h0000, 16'd3, 4, "R1", r);
    chk(r == 3, "R1", "first request at address 0 reads", r, 3);
  endtask

  task automatic t_miss_fill();
    int r;
    request(16'h0100, 16'd5, 6, "R3", r);
    chk(r == 5, "R4", "read count", r, 5);
    fetch_chk(0, word_of(16'h0100), "R5");
    fetch_chk(4, word_of(16'h0104), "R6");
    fetch_chk(2, word_of(16'h0102), "R5");
  endtask

  task automatic t_hit();
    int r;
    request(16'h0100, 16'd9, 0, "R2", r);
    chk(r == 0, "R2", "reads on hit", r, 0);
    chk(!err, "R2", "err on hit", err, 0);
    fetch_chk(4, word_of(16'h0104), "R2");
  endtask

  task automatic t_full_capacity();
    int r;
    request(16'h2000, 16'(DEPTH), DEPTH + 1, "R3", r);
    chk(r == DEPTH, "R4", "reads for full method", r, DEPTH);
    fetch_chk(DEPTH - 1, word_of(16'h2000 + 16'(DEPTH - 1)), "R5");
    fetch_chk(0, word_of(16'h2000), "R5");
  endtask

  task automatic t_bad_len();
    int r;
    request(16'h3000, 16'(DEPTH + 1), 0, "R7", r);
    chk(r == 0, "R7", "reads on oversize", r, 0);
    chk(err, "R7", "err on oversize", err, 1);
    request(16'h3100, 16'd0, 0, "R7", r);
    chk(err && r == 0, "R7", "err on zero length", err, 1);
    request(16'h2000, 16'd4, 0, "R7", r);
    chk(!err, "R7", "err cleared by legal request", err, 0);
    chk(r == 0, "R7", "old method still loaded", r, 0);
    fetch_chk(7, word_of(16'h2007), "R7");
  endtask

  task automatic t_busy_ignore();
    int k = 0;
    int r;
    @(negedge clk);
    req_valid = 1'b1; req_start = 16'h0400; req_len = 16'd8;
    @(negedge clk);
    req_valid = 1'b0;
    while (busy && k < 2000) begin
      if (k == 2) begin req_valid = 1'b1; req_start = 16'h0500; req_len = 16'd3; end
      else req_valid = 1'b0;
      k++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(k == 9, "R8", "busy cycles with injected request", k, 9);
    fetch_chk(7, word_of(16'h0407), "R8");
    request(16'h0400, 16'd8, 0, "R8", r);
    chk(r == 0, "R8", "original method loaded", r, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_first_miss();
    t_miss_fill();
    t_hit();
    t_full_capacity();
    t_bad_len();
    t_busy_ignore();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule